// File: doc/BRIEF.md
# Configurable UART Frame Decoder

This block recovers asynchronous serial frames from a single line that the system clock oversamples. While idle it watches for the line dropping from high to low; that clock becomes the frame origin, and every later bit is sampled once, at the middle of its bit period, counted in clocks from the origin. The first sampled bit is the start bit. Then come 5 to 9 data bits, an optional parity bit and one stop bit. The decoder then goes back to watching for the next falling edge.

The clocks-per-bit divisor, data length, parity mode, parity-check enable and bit order are runtime inputs. They are latched at the falling edge that opens a frame, so software or a wrapper may change them at any time without disturbing a frame in flight. A recovered word is presented with a one-clock strobe. Three one-clock flags report a start bit that reads high, a parity mismatch and a stop bit that reads low. A start bit that reads high is reported but does not abort the frame. Two instances can sit side by side to watch both directions of a link.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, data_o is 0 and data_valid_o, start_err_o, parity_err_o and frame_err_o are all low.
- R2: While idle, a frame begins only on a clock where the line is 0 and was 1 on the previous clock. A line held high produces no strobe and no flag.
- R3: With C = clks_per_bit_i, frame bit n is sampled floor(C/2) + n*C clocks after the origin. Index 0 is the start bit, indices 1..N are data, then parity (if any), then stop. Each result appears on the outputs one clock after its sample. C must be at least 4.
- R4: data_len_i selects N data bits. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. data_o bits at and above position N are always 0.
- R5: With msb_first_i = 0, the first data bit on the line lands in data_o[0]. With msb_first_i = 1, it lands in data_o[N-1].
- R6: parity_mode_i encodings are 0 none, 1 odd, 2 even, 3 zero and 4 one; codes 5 to 7 act as none. The parity bit is in error when the ones count over the data and parity bits is even (odd mode) or odd (even mode), when the parity bit is 1 (zero mode), or when it is 0 (one mode).
- R7: parity_err_o pulses for one clock after a parity bit in error is sampled, and only when parity_chk_i was 1 at the frame's start edge. With the check off, a bad parity bit raises no flag and the word is still delivered.
- R8: With no parity, no parity slot exists: the stop bit is sampled at index N+1. A new frame may start on the clock right after the stop bit period ends.
- R9: A start bit that samples 1 pulses start_err_o for one clock, and the rest of the frame is still received and delivered.
- R10: A stop bit that samples 0 pulses frame_err_o for one clock. The decoder then returns to idle and decodes the next frame normally.
- R11: data_valid_o is high for exactly one clock per frame, one clock after the last data bit is sampled. data_o changes only on that clock and holds its value until the next one.
- R12: All configuration inputs are captured at the start edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial line, idle high |
| clks_per_bit_i | input | CNT_W | Bit period in clocks (at least 4) |
| data_len_i | input | 4 | Data bits per frame, 5 to 9 |
| parity_mode_i | input | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one |
| parity_chk_i | input | 1 | Enables the parity error flag |
| msb_first_i | input | 1 | 0: first bit is the LSB, 1: first bit is the MSB |
| data_o | output | 9 | Last recovered word, zero-extended |
| data_valid_o | output | 1 | One-clock strobe for a new word |
| start_err_o | output | 1 | One-clock flag: start bit read high |
| parity_err_o | output | 1 | One-clock flag: parity mismatch |
| frame_err_o | output | 1 | One-clock flag: stop bit read low |

## Verification
On every cycle, the assertions check that each strobe lasts a single clock and that no two result pulses coincide. They also check that data_o moves only with its strobe, that the word never carries bits above the captured length, and that the start and stop flags agree with the line value one clock earlier. The bench's frames are the only way to show the rest: that the mid-bit sampling points land correctly across divisors, that both bit orders and all parity modes decode correctly, and that length clamping and the missing parity slot behave as required. The frames also show recovery after start and stop errors, and that configuration changed mid-frame is ignored.

// File: rtl/uart_frame_pkg.sv
`timescale 1ns/1ps
package uart_frame_pkg;
    localparam int MAX_BITS = 9;
    localparam int LEN_W    = 4;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        par_mode_e        mode;
        logic             chk;
        logic             msb;
    } frame_cfg_t;

    typedef struct packed {
        rx_state_e           st;
        logic                prev;
        logic [LEN_W-1:0]    idx;
        logic [MAX_BITS-1:0] word;
        frame_cfg_t          cfg;
        logic [MAX_BITS-1:0] dout;
        logic                vld;
        logic                serr;
        logic                perr;
        logic                ferr;
    } rx_regs_t;
endpackage

// File: rtl/uart_bit_timer.sv
`timescale 1ns/1ps
module uart_bit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cpb_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cpb;
        logic             first;
    } tmr_t;

    localparam tmr_t TMR_RST = '{cnt: '0, cpb: CNT_W'(2), first: 1'b1};

    tmr_t q, d;
    logic [CNT_W-1:0] target;

    always_comb begin
        target = q.first ? (q.cpb >> 1) : q.cpb;
        tick_o = run_i && (q.cnt == target);
        d = q;
        if (start_i) begin
            d.cnt   = CNT_W'(1);
            d.cpb   = (cpb_i < CNT_W'(2)) ? CNT_W'(2) : cpb_i;
            d.first = 1'b1;
        end else if (tick_o) begin
            d.cnt   = CNT_W'(1);
            d.first = 1'b0;
        end else if (run_i) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TMR_RST;
        else        q <= d;
    end
endmodule

// File: rtl/uart_word_shift.sv
`timescale 1ns/1ps
module uart_word_shift
    import uart_frame_pkg::*;
(
    input  logic [MAX_BITS-1:0] word_i,
    input  logic                bit_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                msb_first_i,
    output logic [MAX_BITS-1:0] word_o
);
    logic [LEN_W-1:0] top_idx;
    assign top_idx = len_i - LEN_W'(1);

    for (genvar k = 0; k < MAX_BITS; k++) begin : g_bit
        logic from_above;
        logic from_below;
        if (k == MAX_BITS - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_mid
            assign from_above = word_i[k+1];
        end
        if (k == 0) begin : g_low
            assign from_below = bit_i;
        end else begin : g_up
            assign from_below = word_i[k-1];
        end
        assign word_o[k] = msb_first_i ? from_below
                         : ((LEN_W'(k) == top_idx) ? bit_i : from_above);
    end
endmodule

// File: rtl/uart_parity_eval.sv
`timescale 1ns/1ps
module uart_parity_eval
    import uart_frame_pkg::*;
(
    input  logic [MAX_BITS-1:0] word_i,
    input  logic                pbit_i,
    input  par_mode_e           mode_i,
    output logic                ok_o
);
    logic odd_ones;
    assign odd_ones = (^word_i) ^ pbit_i;

    always_comb begin
        case (mode_i)
            PAR_ODD:  ok_o = odd_ones;
            PAR_EVEN: ok_o = !odd_ones;
            PAR_ZERO: ok_o = !pbit_i;
            PAR_ONE:  ok_o = pbit_i;
            default:  ok_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx
    import uart_frame_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_i,
    input  logic [CNT_W-1:0]    clks_per_bit_i,
    input  logic [LEN_W-1:0]    data_len_i,
    input  logic [2:0]          parity_mode_i,
    input  logic                parity_chk_i,
    input  logic                msb_first_i,
    output logic [MAX_BITS-1:0] data_o,
    output logic                data_valid_o,
    output logic                start_err_o,
    output logic                parity_err_o,
    output logic                frame_err_o
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(5);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

    localparam rx_regs_t REGS_RST = '{
        st:   ST_IDLE,
        prev: 1'b1,
        idx:  '0,
        word: '0,
        cfg:  '{len: LEN_MIN, mode: PAR_NONE, chk: 1'b0, msb: 1'b0},
        dout: '0,
        vld:  1'b0,
        serr: 1'b0,
        perr: 1'b0,
        ferr: 1'b0
    };

    rx_regs_t q, d;
    logic                start_edge;
    logic                running;
    logic                tick;
    logic                par_ok;
    logic [MAX_BITS-1:0] shifted;
    logic [LEN_W-1:0]    cur_len;

    assign start_edge = (q.st == ST_IDLE) && q.prev && !line_i;
    assign running    = (q.st != ST_IDLE);
    assign cur_len    = q.cfg.len;

    uart_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_edge),
        .run_i   (running),
        .cpb_i   (clks_per_bit_i),
        .tick_o  (tick)
    );

    uart_word_shift u_shift (
        .word_i      (q.word),
        .bit_i       (line_i),
        .len_i       (q.cfg.len),
        .msb_first_i (q.cfg.msb),
        .word_o      (shifted)
    );

    uart_parity_eval u_par (
        .word_i (q.word),
        .pbit_i (line_i),
        .mode_i (q.cfg.mode),
        .ok_o   (par_ok)
    );

    always_comb begin
        d      = q;
        d.prev = line_i;
        d.vld  = 1'b0;
        d.serr = 1'b0;
        d.perr = 1'b0;
        d.ferr = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_edge) begin
                    d.st   = ST_START;
                    d.idx  = '0;
                    d.word = '0;
                    if (data_len_i < LEN_MIN)      d.cfg.len = LEN_MIN;
                    else if (data_len_i > LEN_MAX) d.cfg.len = LEN_MAX;
                    else                           d.cfg.len = data_len_i;
                    d.cfg.mode = (parity_mode_i > 3'd4) ? PAR_NONE
                                                        : par_mode_e'(parity_mode_i);
                    d.cfg.chk  = parity_chk_i;
                    d.cfg.msb  = msb_first_i;
                end
            end
            ST_START: begin
                if (tick) begin
                    d.serr = line_i;
                    d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.word = shifted;
                    if (q.idx == q.cfg.len - LEN_W'(1)) begin
                        d.dout = shifted;
                        d.vld  = 1'b1;
                        d.st   = (q.cfg.mode == PAR_NONE) ? ST_STOP : ST_PAR;
                    end else begin
                        d.idx = q.idx + LEN_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    d.perr = !par_ok && q.cfg.chk;
                    d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.ferr = !line_i;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign data_o       = q.dout;
    assign data_valid_o = q.vld;
    assign start_err_o  = q.serr;
    assign parity_err_o = q.perr;
    assign frame_err_o  = q.ferr;
endmodule

// File: rtl/uart_frame_rx_chk.sv
`timescale 1ns/1ps
module uart_frame_rx_chk
    import uart_frame_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                line_i,
    input logic [MAX_BITS-1:0] data_o,
    input logic                data_valid_o,
    input logic                start_err_o,
    input logic                parity_err_o,
    input logic                frame_err_o,
    input logic [LEN_W-1:0]    cur_len
);
    AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o); // R11

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid_o |-> $stable(data_o)); // R11

    AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid_o, start_err_o, parity_err_o, frame_err_o})); // R7

    AST_WORD_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> ((data_o >> cur_len) == '0)); // R4

    AST_START_FLAG_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> $past(line_i)); // R9

    AST_FRAME_FLAG_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> !$past(line_i)); // R10
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .data_o       (data_o),
    .data_valid_o (data_valid_o),
    .start_err_o  (start_err_o),
    .parity_err_o (parity_err_o),
    .frame_err_o  (frame_err_o),
    .cur_len      (cur_len)
);

// File: tb/uart_frame_rx_test.sv
`timescale 1ns/1ps
module uart_frame_rx_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_i = 1'b1;
    logic [CNT_W-1:0] clks_per_bit_i = CNT_W'(8);
    logic [3:0]       data_len_i = 4'd8;
    logic [2:0]       parity_mode_i = 3'd0;
    logic             parity_chk_i = 1'b1;
    logic             msb_first_i = 1'b0;
    logic [8:0]       data_o;
    logic             data_valid_o, start_err_o, parity_err_o, frame_err_o;

    int n_checks = 0;
    int n_err = 0;
    int v_cnt = 0, s_cnt = 0, p_cnt = 0, f_cnt = 0;
    logic [8:0] v_data = '0;

    always #10 clk = ~clk;

    uart_frame_rx #(.CNT_W(CNT_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_i         (line_i),
        .clks_per_bit_i (clks_per_bit_i),
        .data_len_i     (data_len_i),
        .parity_mode_i  (parity_mode_i),
        .parity_chk_i   (parity_chk_i),
        .msb_first_i    (msb_first_i),
        .data_o         (data_o),
        .data_valid_o   (data_valid_o),
        .start_err_o    (start_err_o),
        .parity_err_o   (parity_err_o),
        .frame_err_o    (frame_err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid_o) begin
                v_cnt  = v_cnt + 1;
                v_data = data_o;
            end
            if (start_err_o)  s_cnt = s_cnt + 1;
            if (parity_err_o) p_cnt = p_cnt + 1;
            if (frame_err_o)  f_cnt = f_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b, input int c);
        line_i = b;
        repeat (c) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] v, input int c, input int len_in,
                              input int mode, input bit msb, input bit chk,
                              input bit bad_par, input bit bad_stop, input bit bad_start,
                              input bit scramble, input int gap, input string tag);
        int n, mask, b_v, b_s, b_p, b_f, exp_p;
        logic [8:0] vm;
        logic pbit;
        bit has_par;
        n    = (len_in < 5) ? 5 : ((len_in > 9) ? 9 : len_in);
        mask = (1 << n) - 1;
        vm   = v & mask[8:0];
        has_par = (mode >= 1 && mode <= 4);
        clks_per_bit_i = CNT_W'(c);
        data_len_i     = 4'(len_in);
        parity_mode_i  = 3'(mode);
        parity_chk_i   = chk;
        msb_first_i    = msb;
        b_v = v_cnt; b_s = s_cnt; b_p = p_cnt; b_f = f_cnt;
        line_i = 1'b0;
        @(negedge clk);
        if (scramble) begin
            clks_per_bit_i = CNT_W'(c + 5);
            data_len_i     = (n == 9) ? 4'd5 : 4'd9;
            parity_mode_i  = has_par ? 3'd0 : 3'd1;
            parity_chk_i   = ~chk;
            msb_first_i    = ~msb;
        end
        hold_bit(bad_start ? 1'b1 : 1'b0, c - 1);
        for (int i = 0; i < n; i++) begin
            hold_bit(msb ? vm[n-1-i] : vm[i], c);
        end
        if (has_par) begin
            case (mode)
                1: pbit = ~(^vm);
                2: pbit = ^vm;
                3: pbit = 1'b0;
                default: pbit = 1'b1;
            endcase
            if (bad_par) pbit = ~pbit;
            hold_bit(pbit, c);
        end
        hold_bit(bad_stop ? 1'b0 : 1'b1, c);
        hold_bit(1'b1, gap);
        exp_p = (has_par && bad_par && chk) ? 1 : 0;
        check((v_cnt - b_v) == 1, {tag, " R11 strobe count"}, v_cnt - b_v, 1);
        check(v_data == vm, {tag, " word"}, int'(v_data), int'(vm));
        check(data_o == vm, {tag, " R11 held word"}, int'(data_o), int'(vm));
        check((s_cnt - b_s) == int'(bad_start), {tag, " R9 start flag"}, s_cnt - b_s, int'(bad_start));
        check((p_cnt - b_p) == exp_p, {tag, " R6 R7 parity flag"}, p_cnt - b_p, exp_p);
        check((f_cnt - b_f) == int'(bad_stop), {tag, " R10 stop flag"}, f_cnt - b_f, int'(bad_stop));
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(data_o == 9'd0, "R1 data_o", int'(data_o), 0);
        check({data_valid_o, start_err_o, parity_err_o, frame_err_o} == 4'b0,
              "R1 strobes", int'({data_valid_o, start_err_o, parity_err_o, frame_err_o}), 0);
        // R2 idle high line
        repeat (60) @(negedge clk);
        check((v_cnt + s_cnt + p_cnt + f_cnt) == 0, "R2 idle pulses", v_cnt + s_cnt + p_cnt + f_cnt, 0);

        send_frame(9'h0A5, 8, 8, 0, 1'b0, 1'b1, 0, 0, 0, 0, 3, "R5 lsb");
        send_frame(9'h02C, 8, 8, 0, 1'b1, 1'b1, 0, 0, 0, 0, 3, "R5 msb");
        send_frame(9'h013, 4, 5, 0, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R4 len5");
        send_frame(9'h155, 7, 9, 2, 1'b1, 1'b1, 0, 0, 0, 0, 2, "R4 len9");
        send_frame(9'h1FF, 6, 3, 0, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R4 clamp low");
        send_frame(9'h1AB, 6, 13, 1, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R4 clamp high");
        for (int m = 1; m <= 4; m++) begin
            send_frame(9'h05A, 9, 8, m, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R6 good parity");
            send_frame(9'h0C3, 9, 7, m, 1'b1, 1'b1, 1, 0, 0, 0, 2, "R6 bad parity");
        end
        send_frame(9'h077, 8, 8, 1, 1'b0, 1'b0, 1, 0, 0, 0, 2, "R7 check off");
        send_frame(9'h0E1, 8, 8, 6, 1'b0, 1'b1, 1, 0, 0, 0, 2, "R6 code6 none");
        send_frame(9'h031, 5, 6, 0, 1'b0, 1'b1, 0, 0, 0, 0, 1, "R8 back to back a");
        send_frame(9'h02E, 5, 6, 0, 1'b0, 1'b1, 0, 0, 0, 0, 1, "R8 back to back b");
        send_frame(9'h099, 10, 8, 2, 1'b0, 1'b1, 0, 0, 1, 0, 2, "R9 bad start");
        send_frame(9'h066, 10, 8, 0, 1'b0, 1'b1, 0, 1, 0, 0, 2, "R10 bad stop");
        send_frame(9'h0F0, 10, 8, 0, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R10 recovery");
        send_frame(9'h0B4, 12, 8, 1, 1'b0, 1'b1, 1, 0, 0, 1, 2, "R12 scrambled");
        send_frame(9'h14B, 7, 9, 3, 1'b1, 1'b1, 0, 0, 0, 1, 2, "R12 scrambled msb");
        send_frame(9'h0D2, 7, 8, 0, 1'b0, 1'b1, 0, 0, 0, 0, 2, "R3 odd divisor");

        for (int k = 0; k < 60; k++) begin
            int c, ln, md, g;
            bit ms, ck, bp, bs, bst, sc;
            logic [8:0] v;
            c   = 4 + int'($urandom_range(16));
            ln  = 5 + int'($urandom_range(4));
            md  = int'($urandom_range(5));
            ms  = 1'($urandom_range(1));
            ck  = ($urandom_range(3) != 0);
            bp  = ($urandom_range(3) == 0);
            bs  = ($urandom_range(5) == 0);
            bst = ($urandom_range(5) == 0);
            sc  = ($urandom_range(4) == 0);
            g   = 1 + int'($urandom_range(3));
            v   = 9'($urandom_range(511));
            send_frame(v, c, ln, md, ms, ck, bp, bs, bst, sc, g, "R3 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule